// File: doc/BRIEF.md
# Clock-Steering Elastic Sample Buffer

This block decouples an audio sample stream written on a recovered input clock from the same stream read on a local slave clock. Samples are kept in a dual-port RAM. Separate binary write and read counters address the RAM. Each counter crosses into the other domain as Gray code through a two-flop synchroniser. The read side computes the occupancy as the synchronised write count minus its own read count. That occupancy is exposed at full resolution.

The occupancy is the error input of a slow proportional-integral loop. At a programmable interval, normally tens of seconds of slave clock, the loop compares the occupancy with a setpoint of half the depth. It then writes a new code for the DAC that trims the slave oscillator. A small deadband around the setpoint keeps DAC quantisation from making the loop hunt between neighbouring codes. The integrator and the DAC code are both clamped.

Running empty and running full are faults, not control signals. Each one latches a sticky flag. After reset, and again after an underrun, the read side outputs silence until the buffer has refilled to the setpoint.

Top module: `elastic_sample_buffer`

## Requirements
- R1: Every accepted sample comes out on `rd_data_o` in write order. For each `rd_req_i` pulse, `rd_valid_o` is high during the following read-clock cycle, and `rd_data_o` carries the sample or zero.
- R2: `fill_o` equals accepted writes minus popped samples once a write has had a few read-clock cycles to cross. It never exceeds the depth.
- R3: A write that arrives while the buffer holds DEPTH samples is dropped. The overrun flag is set and stays set until reset. The stored samples are not disturbed.
- R4: After reset, read requests are answered with zero and pop nothing until `fill_o` reaches DEPTH/2. Only then does playing start.
- R5: A read request while playing with an empty buffer sets the sticky underrun flag and returns zero. The block then mutes, answering zero without popping, until `fill_o` is back at DEPTH/2.
- R6: Every UPDATE_TICKS read-clock cycles, and only while playing, `dac_load_o` pulses for one cycle and `dac_o` takes the new code. The error e is the fill before that edge minus DEPTH/2. The new integrator I is the old I plus e. The code is 2^(DAC_W-1) + KP*e + KI*I. `dac_o` never changes in any other cycle.
- R7: The integrator is held within plus or minus INT_LIM after every update.
- R8: An error whose magnitude is at most DEADBAND is treated as zero in both terms. A fill parked in the deadband therefore leaves the code unchanged.
- R9: `dac_o` resets to mid-scale (32768 for 16 bits) and saturates at 0 and 2^DAC_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk_i | input | 1 | Recovered input sample clock |
| rd_clk_i | input | 1 | Local slave clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| wr_valid_i | input | 1 | Write strobe, one sample per cycle |
| wr_data_i | input | DATA_W | Sample to store |
| overrun_o | output | 1 | Sticky write-while-full flag (write domain) |
| rd_req_i | input | 1 | Sample request from the output stage |
| rd_valid_o | output | 1 | Response strobe, one cycle after a request |
| rd_data_o | output | DATA_W | Sample, or zero while held or muted |
| fill_o | output | ADDR_W+1 | Occupancy seen by the read domain |
| underrun_o | output | 1 | Sticky read-while-empty flag (read domain) |
| dac_o | output | DAC_W | Oscillator trim code |
| dac_load_o | output | 1 | One-cycle strobe when `dac_o` is updated |

## Verification
The hardest states to reach are the loop corners. One is a saturated integrator meeting a sign reversal of the error. The others are the two DAC rails and a fill parked inside the deadband. All of them need the fill held still across many update periods while the two clocks keep drifting. The stimulus first runs constrained-random traffic that keeps the occupancy clear of both ends. It then parks the buffer at full for thirty periods, reverses the error immediately after a load strobe and checks the first new code. Finally it drains into underrun and parks the fill at 1 and at 9, while a monitor predicts every load from the fill seen just before it.

// File: rtl/efb_pkg.sv
`timescale 1ns/1ps
package efb_pkg;
  typedef enum logic {
    ST_FILL = 1'b0,
    ST_PLAY = 1'b1
  } rd_state_e;
endpackage

// File: rtl/efb_gray_xfer.sv
`timescale 1ns/1ps
// Binary count -> Gray (source reg) -> 2-flop sync -> binary in destination.
module efb_gray_xfer #(
  parameter int W = 5
) (
  input  logic         src_clk_i,
  input  logic         dst_clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] bin_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] gray_src_q, meta_q, sync_q;

  always_ff @(posedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni) gray_src_q <= '0;
    else         gray_src_q <= bin_i ^ (bin_i >> 1);
  end

  always_ff @(posedge dst_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_src_q;
      sync_q <= meta_q;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bin_o[i] = ^sync_q[W-1:i];
  end
endmodule

// File: rtl/efb_ram.sv
`timescale 1ns/1ps
module efb_ram #(
  parameter int DW = 24,
  parameter int AW = 6
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/efb_rd_ctrl.sv
`timescale 1ns/1ps
module efb_rd_ctrl
  import efb_pkg::*;
#(
  parameter int DW = 24,
  parameter int AW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_req_i,
  input  logic [AW:0]   wr_bin_i,
  input  logic [DW-1:0] ram_rdata_i,
  output logic [AW:0]   rd_bin_o,
  output logic [AW:0]   fill_o,
  output logic          play_o,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o,
  output logic          underrun_o
);
  localparam int          DEPTH   = 1 << AW;
  localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);
  localparam logic [AW:0] SP_V    = (AW+1)'(DEPTH / 2);

  rd_state_e     state_q;
  logic [AW:0]   rd_bin_q, fill;
  logic          empty, pop, starve;
  logic          rd_valid_q, underrun_q;
  logic [DW-1:0] rd_data_q;

  assign fill   = wr_bin_i - rd_bin_q;
  assign empty  = (fill == '0);
  assign pop    = rd_req_i && (state_q == ST_PLAY) && !empty;
  assign starve = rd_req_i && (state_q == ST_PLAY) && empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_FILL;
      rd_bin_q   <= '0;
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
      underrun_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_req_i;
      if (rd_req_i) rd_data_q <= pop ? ram_rdata_i : '0;
      if (pop) rd_bin_q <= rd_bin_q + 1'b1;
      if (starve) begin
        underrun_q <= 1'b1;
        state_q    <= ST_FILL;
      end else if (state_q == ST_FILL && fill >= SP_V) begin
        state_q <= ST_PLAY;
      end
    end
  end

  assign rd_bin_o   = rd_bin_q;
  assign fill_o     = fill;
  assign play_o     = (state_q == ST_PLAY);
  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;
  assign underrun_o = underrun_q;

  // R2
  r2_fill_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill <= DEPTH_V);
  // R4
  r4_hold_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FILL && rd_req_i) |=> (rd_data_q == '0 && $stable(rd_bin_q)));
  // R5
  r5_underrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_q |=> underrun_q);
  // R5
  r5_starve_mutes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    starve |=> (state_q == ST_FILL && underrun_q));
endmodule

// File: rtl/efb_pi.sv
`timescale 1ns/1ps
module efb_pi #(
  parameter int AW           = 6,
  parameter int DAC_W        = 16,
  parameter int UPDATE_TICKS = 614_400_000,
  parameter int KP           = 64,
  parameter int KI           = 4,
  parameter int INT_LIM      = 4096,
  parameter int DEADBAND     = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [AW:0]      fill_i,
  output logic [DAC_W-1:0] dac_o,
  output logic             dac_load_o
);
  localparam int          SP    = (1 << AW) / 2;
  localparam int          MID   = 1 << (DAC_W - 1);
  localparam int          MAXC  = (1 << DAC_W) - 1;
  localparam int          TW    = $clog2(UPDATE_TICKS + 1);
  localparam logic [TW-1:0] LAST = TW'(UPDATE_TICKS - 1);

  logic [TW-1:0]    tick_q;
  logic             tick;
  int               integ_q, err, err_db, integ_n, code_n;
  logic [DAC_W-1:0] dac_q;
  logic             load_q;

  assign tick = (tick_q == LAST);

  always_comb begin
    err    = int'(fill_i) - SP;
    err_db = (err <= DEADBAND && err >= -DEADBAND) ? 0 : err;
    integ_n = integ_q + err_db;
    if (integ_n > INT_LIM)  integ_n = INT_LIM;
    if (integ_n < -INT_LIM) integ_n = -INT_LIM;
    code_n = MID + KP * err_db + KI * integ_n;
    if (code_n > MAXC) code_n = MAXC;
    if (code_n < 0)    code_n = 0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q  <= '0;
      integ_q <= 0;
      dac_q   <= DAC_W'(MID);
      load_q  <= 1'b0;
    end else begin
      tick_q <= tick ? '0 : tick_q + 1'b1;
      load_q <= tick && run_i;
      if (tick && run_i) begin
        integ_q <= integ_n;
        dac_q   <= DAC_W'(code_n);
      end
    end
  end

  assign dac_o      = dac_q;
  assign dac_load_o = load_q;

  // R6
  r6_code_only_on_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_q |-> $stable(dac_q));
  // R6
  r6_no_load_when_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !load_q);
  // R7
  r7_integ_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    integ_q <= INT_LIM && integ_q >= -INT_LIM);
endmodule

// File: rtl/elastic_sample_buffer.sv
`timescale 1ns/1ps
module elastic_sample_buffer #(
  parameter int DATA_W       = 24,
  parameter int ADDR_W       = 6,
  parameter int DAC_W        = 16,
  parameter int UPDATE_TICKS = 614_400_000,
  parameter int KP           = 64,
  parameter int KI           = 4,
  parameter int INT_LIM      = 4096,
  parameter int DEADBAND     = 1
) (
  input  logic              wr_clk_i,
  input  logic              rd_clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              overrun_o,
  input  logic              rd_req_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [ADDR_W:0]   fill_o,
  output logic              underrun_o,
  output logic [DAC_W-1:0]  dac_o,
  output logic              dac_load_o
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH_V = PW'(1 << ADDR_W);

  logic [PW-1:0]     wr_bin_q, rd_bin_w, wr_bin_r, rd_bin, wr_level, fill;
  logic              full, accept, overrun_q, play;
  logic [DATA_W-1:0] ram_rdata;

  // write domain
  assign wr_level = wr_bin_q - rd_bin_w;
  assign full     = (wr_level == DEPTH_V);
  assign accept   = wr_valid_i && !full;

  always_ff @(posedge wr_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_bin_q  <= '0;
      overrun_q <= 1'b0;
    end else begin
      if (accept) wr_bin_q <= wr_bin_q + 1'b1;
      if (wr_valid_i && full) overrun_q <= 1'b1;
    end
  end

  efb_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
    .wclk_i (wr_clk_i),
    .we_i   (accept),
    .waddr_i(wr_bin_q[ADDR_W-1:0]),
    .wdata_i(wr_data_i),
    .raddr_i(rd_bin[ADDR_W-1:0]),
    .rdata_o(ram_rdata)
  );

  efb_gray_xfer #(.W(PW)) u_wr2rd (
    .src_clk_i(wr_clk_i), .dst_clk_i(rd_clk_i), .rst_ni(rst_ni),
    .bin_i(wr_bin_q), .bin_o(wr_bin_r)
  );

  efb_gray_xfer #(.W(PW)) u_rd2wr (
    .src_clk_i(rd_clk_i), .dst_clk_i(wr_clk_i), .rst_ni(rst_ni),
    .bin_i(rd_bin), .bin_o(rd_bin_w)
  );

  efb_rd_ctrl #(.DW(DATA_W), .AW(ADDR_W)) u_rd (
    .clk_i      (rd_clk_i),
    .rst_ni     (rst_ni),
    .rd_req_i   (rd_req_i),
    .wr_bin_i   (wr_bin_r),
    .ram_rdata_i(ram_rdata),
    .rd_bin_o   (rd_bin),
    .fill_o     (fill),
    .play_o     (play),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o),
    .underrun_o (underrun_o)
  );

  efb_pi #(
    .AW(ADDR_W), .DAC_W(DAC_W), .UPDATE_TICKS(UPDATE_TICKS),
    .KP(KP), .KI(KI), .INT_LIM(INT_LIM), .DEADBAND(DEADBAND)
  ) u_pi (
    .clk_i     (rd_clk_i),
    .rst_ni    (rst_ni),
    .run_i     (play),
    .fill_i    (fill),
    .dac_o     (dac_o),
    .dac_load_o(dac_load_o)
  );

  assign fill_o    = fill;
  assign overrun_o = overrun_q;

  // R3
  r3_level_bound_chk: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    wr_level <= DEPTH_V);
  // R3
  r3_drop_when_full_chk: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    (wr_valid_i && full) |=> ($stable(wr_bin_q) && overrun_q));
  // R3
  r3_overrun_sticky_chk: assert property (@(posedge wr_clk_i) disable iff (!rst_ni)
    overrun_q |=> overrun_q);
endmodule

// File: tb/elastic_sample_buffer_tb.sv
`timescale 1ns/1ps
module elastic_sample_buffer_tb;
  localparam int DW = 16, AW = 4, DEPTH = 16, SP = 8;
  localparam int UT = 64, KP = 4096, KI = 512, IL = 16, DB = 1;

  logic          wr_clk = 0, rd_clk = 0, rst_ni = 0;
  logic          wr_valid = 0, rd_req = 0;
  logic [DW-1:0] wr_data = '0;
  logic          overrun_o, rd_valid_o, underrun_o, dac_load_o;
  logic [DW-1:0] rd_data_o;
  logic [AW:0]   fill_o;
  logic [15:0]   dac_o;

  always #2.75 wr_clk = ~wr_clk;
  always #2.5  rd_clk = ~rd_clk;

  elastic_sample_buffer #(
    .DATA_W(DW), .ADDR_W(AW), .DAC_W(16), .UPDATE_TICKS(UT),
    .KP(KP), .KI(KI), .INT_LIM(IL), .DEADBAND(DB)
  ) u_dut (
    .wr_clk_i(wr_clk), .rd_clk_i(rd_clk), .rst_ni(rst_ni),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .overrun_o(overrun_o),
    .rd_req_i(rd_req), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .fill_o(fill_o), .underrun_o(underrun_o),
    .dac_o(dac_o), .dac_load_o(dac_load_o)
  );

  int n_run = 0, n_fail = 0;
  bit finished = 0;
  logic [DW-1:0] sb[$];
  int b_cnt = 0, m_integ = 0, last_fill = 0, load_cnt = 0, gap = 0;
  bit seen_load = 0, wdone = 0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int clampi(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  function automatic int model_code(int f);
    int e;
    e = f - SP;
    if (e >= -DB && e <= DB) e = 0;
    m_integ = clampi(m_integ + e, -IL, IL);
    return clampi(32768 + KP * e + KI * m_integ, 0, 65535);
  endfunction

  // loop monitor: every load predicted from the fill seen before the edge
  always @(negedge rd_clk) begin
    if (rst_ni) begin
      if (dac_load_o) begin
        int exp_code;
        exp_code = model_code(last_fill);
        chk(dac_o == 16'(exp_code), "R6 load code", dac_o, exp_code);
        if (seen_load) chk((gap % UT) == 0, "R6 load period", gap, UT);
        seen_load = 1;
        gap = 0;
        load_cnt++;
      end
      gap++;
      last_fill = int'(fill_o);
    end
  end

  task automatic push(logic [DW-1:0] d, bit keep);
    @(negedge wr_clk);
    wr_valid = 1;
    wr_data  = d;
    if (keep) begin
      sb.push_back(d);
      b_cnt++;
    end
    @(negedge wr_clk);
    wr_valid = 0;
  endtask

  task automatic pull(bit expect_data, string tag);
    logic [DW-1:0] exp_d;
    exp_d = '0;
    @(negedge rd_clk);
    rd_req = 1;
    if (expect_data) begin
      exp_d = sb.pop_front();
      b_cnt--;
    end
    @(negedge rd_clk);
    rd_req = 0;
    chk(rd_valid_o == 1'b1, "R1 valid strobe", rd_valid_o, 1);
    chk(rd_data_o == exp_d, tag, rd_data_o, exp_d);
  endtask

  task automatic wait_rd(int n);
    repeat (n) @(negedge rd_clk);
  endtask

  task automatic wait_load();
    do @(negedge rd_clk); while (dac_load_o !== 1'b1);
  endtask

  initial begin
    #900000;
    if (!finished) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int n, lc;
    void'($urandom(32'd1234));
    wait_rd(4);
    // reset state
    chk(dac_o == 16'd32768, "R9 reset mid-scale", dac_o, 32768);
    chk(fill_o == 0, "R2 reset fill", fill_o, 0);
    chk(overrun_o == 0, "R3 reset flag", overrun_o, 0);
    chk(underrun_o == 0, "R5 reset flag", underrun_o, 0);
    chk(rd_valid_o == 0 && dac_load_o == 0, "R1 reset strobes", rd_valid_o, 0);
    rst_ni = 1;

    // priming: requests below the setpoint are answered with silence
    for (int i = 0; i < 5; i++) push(16'(16'h100 + i), 1);
    wait_rd(12);
    chk(fill_o == 5, "R2 fill after writes", fill_o, 5);
    pull(0, "R4 held data zero");
    wait_rd(4);
    chk(fill_o == 5, "R4 held no pop", fill_o, 5);
    for (int i = 0; i < 3; i++) push(16'(16'h200 + i), 1);
    wait_rd(12);
    chk(fill_o == 8, "R2 fill at setpoint", fill_o, 8);

    // constrained random traffic away from both ends
    fork
      begin
        for (int i = 0; i < 700; i++) begin
          if (b_cnt <= DEPTH - 5 && ($urandom % 2) == 1) push(16'($urandom), 1);
          else @(negedge wr_clk);
          repeat ($urandom % 3) @(negedge wr_clk);
        end
        wdone = 1;
      end
      begin
        while (!wdone) begin
          if (b_cnt >= 5 && ($urandom % 2) == 1) pull(1, "R1 random order");
          else @(negedge rd_clk);
          repeat (1 + $urandom % 3) @(negedge rd_clk);
        end
      end
    join
    wait_rd(12);
    chk(fill_o == b_cnt, "R2 fill after random", fill_o, b_cnt);
    chk(overrun_o == 0, "R3 no false overrun", overrun_o, 0);
    chk(underrun_o == 0, "R5 no false underrun", underrun_o, 0);

    // overrun: three writes beyond depth are dropped
    n = DEPTH - b_cnt;
    for (int i = 0; i < n + 3; i++) push(16'(16'h3000 + i), i < n);
    wait_rd(12);
    chk(overrun_o == 1, "R3 overrun flag", overrun_o, 1);
    chk(fill_o == DEPTH, "R3 fill capped", fill_o, DEPTH);
    wait_rd(30 * UT);
    chk(dac_o == 16'd65535, "R9 upper rail", dac_o, 65535);

    // reverse error right after a load; clamped integrator gives 16-2
    wait_load();
    repeat (10) pull(1, "R3 contents kept");
    wait_load();
    chk(dac_o == 16'd31744, "R7 integrator clamp", dac_o, 31744);
    chk(overrun_o == 1, "R3 flag sticky", overrun_o, 1);

    // drain to underrun
    repeat (6) pull(1, "R1 drain");
    pull(0, "R5 underrun zero");
    chk(underrun_o == 1, "R5 underrun flag", underrun_o, 1);
    wait_rd(2);
    lc = load_cnt;
    for (int i = 0; i < 3; i++) push(16'(16'h4000 + i), 1);
    wait_rd(12);
    pull(0, "R5 mute zero");
    wait_rd(4);
    chk(fill_o == 3, "R5 mute no pop", fill_o, 3);
    wait_rd(3 * UT);
    chk(load_cnt == lc, "R6 no load while muted", load_cnt, lc);
    for (int i = 0; i < 5; i++) push(16'(16'h4100 + i), 1);
    wait_rd(12);
    pull(1, "R5 resume data");
    chk(underrun_o == 1, "R5 flag sticky", underrun_o, 1);

    // lower rail with fill parked at 1
    repeat (6) pull(1, "R1 drain low");
    wait_rd(25 * UT);
    chk(fill_o == 1, "R2 fill parked low", fill_o, 1);
    chk(dac_o == 16'd0, "R9 lower rail", dac_o, 0);

    // deadband: fill 9 leaves the integrator at -16
    for (int i = 0; i < 8; i++) push(16'(16'h5000 + i), 1);
    wait_rd(12);
    chk(fill_o == 9, "R2 fill at 9", fill_o, 9);
    wait_load();
    chk(dac_o == 16'd24576, "R8 deadband code", dac_o, 24576);
    repeat (3) wait_load();
    chk(dac_o == 16'd24576, "R8 deadband steady", dac_o, 24576);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule